// File: doc/BRIEF.md
# TMDS Transmitter PHY Power-Up Sequencer

This block brings a TMDS transmitter PHY from a quiet, powered-down state to a locked, transmitting state after the video mode changes. A single-cycle start request carries the new pixel clock in kHz. The sequencer latches that value and rejects clocks above 216 MHz. It then drives the PHY's control levels into a safe configuration state and toggles the PHY reset. Next it programs nine 16-bit PHY configuration registers through a clear / request / done-or-error handshake. Several of the values written depend on the pixel-clock band.

After the writes it powers the transmitter up in a fixed order and polls the PLL lock input at a fixed interval. The whole pass runs twice back to back. A one-cycle done pulse ends the run, and a status code reports the outcome. Timeouts are given in microseconds and converted to clock cycles from the control clock frequency parameter.

Top-level states: `S_IDLE` (start moves to `S_CHECK`), `S_CHECK` (clock too high goes to `S_FINISH`, otherwise `S_PREP`), `S_PREP`, `S_QUIET`, `S_RST_REL`, `S_RST_SET`, then `S_WR_GO`/`S_WR_WAIT` repeated for each write (a write failure goes to `S_FINISH`). After the last write the run continues through `S_PWR_ON`, `S_TMDS_LO`, `S_TMDS_HI`, `S_TX_ON`, `S_QUIET_OFF`, `S_LOCK_GO` and `S_LOCK_WAIT`. From `S_LOCK_WAIT`, lock on the first pass returns to `S_PREP` and lock on the second pass goes to `S_FINISH`; a lock timeout also goes to `S_FINISH`. `S_FINISH` always moves to `S_IDLE`. The write engine has its own states `W_IDLE`, `W_CLR`, `W_REQ` and `W_WAIT`.

Top module: `tx_phy_seq`

## Requirements
- R1: A start with a pixel clock above 216000 kHz issues no register write and ends with a done pulse and status 3 (unsupported).
- R2: Whenever a write request is issued, the control levels are: data-enable polarity 1, interface select 0, TMDS enable 0, power enable 0, transmit power-on 0, power-down-quiet 1.
- R3: In every pass the PHY reset output is driven to 0 and then to 1 before the first write, so a two-pass run shows two rising edges of it, and it is 1 during every write.
- R4: Each write pulses the flag-clear output for one cycle, then pulses the request output for one cycle in the next cycle. Address and 16-bit data stay stable while the request waits.
- R5: The write to 0x06 carries 0x0051, 0x00A1, 0x0029 or 0x0040, and the write to 0x15 carries 0x0003, 0x0002, 0x0001 or 0x0000. The band is chosen by pixel clock: up to 45250 kHz, up to 92500 kHz, up to 185000 kHz, or above.
- R6: The write to 0x10 carries 0x091C up to 58400 kHz, 0x06DC up to 74250 kHz, 0x091C up to 118800 kHz, and 0x06DC up to 216000 kHz.
- R7: Above 148500 kHz, the write to 0x09 carries 0x800D and the write to 0x0E carries 0x0129, which is level 9 in bits 9:5 and in bits 4:0. Otherwise they carry 0x8009 and 0x01AD (level 13).
- R8: Each pass makes exactly nine writes in this order: 0x06, 0x15, 0x10, 0x13=0x0000, 0x17=0x0008, 0x19=0x0004, 0x05=0x8000, 0x09, 0x0E.
- R9: After the writes, power enable is set, TMDS enable is driven low and then high, transmit power-on is set, and power-down-quiet is released. Transmit power-on rises only while power enable and TMDS enable are already 1. A successful run ends with status 0.
- R10: Lock is sampled once right after power-up and then every POLL_US microseconds. Lock seen at any sample continues the run. If lock is absent at sample LOCK_POLLS (counting from 0), the run ends with status 2, LOCK_POLLS poll intervals after the first sample.
- R11: An error response, or no done within WR_TMO_US, aborts the run at once with status 1, and no further write is issued.
- R12: A successful run performs the whole pass twice: 18 writes and two releases of power-down-quiet.
- R13: After reset the block is idle with done 0, status 0 and all control outputs low except power-down-quiet. Done lasts exactly one cycle per run. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to run the bring-up |
| pclk_khz_i | input | PCLK_W | Pixel clock in kHz, latched at start |
| lock_i | input | 1 | PHY PLL lock status |
| wr_done_i | input | 1 | Configuration write completed |
| wr_err_i | input | 1 | Configuration write failed |
| wr_clr_o | output | 1 | Clear the port's done/error flags |
| wr_req_o | output | 1 | Issue the configuration write |
| wr_addr_o | output | 8 | PHY register address |
| wr_data_o | output | 16 | Register value (the carrier sends the high byte first) |
| den_pol_o | output | 1 | Data-enable polarity select |
| if_sel_o | output | 1 | PHY interface control select |
| pwr_en_o | output | 1 | PHY power enable |
| tmds_en_o | output | 1 | TMDS output enable |
| txpwron_o | output | 1 | Transmit power-on |
| pddq_o | output | 1 | Power-down-quiet |
| phy_rst_o | output | 1 | PHY reset level |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | 0 OK, 1 write error, 2 lock timeout, 3 unsupported clock |

## Verification
A state that is skipped or out of order shows up as a wrong control level at the first write request. It can also show up as transmit power-on rising before TMDS enable, at the cycle of that edge. A wrong band decode or write index shows up as a wrong address or value, already at the request of that write, and long before lock polling. A miscounted poll or write timer shows up only at the end of the run: done arrives outside its expected window, or with the wrong status code.

// File: rtl/tx_phy_seq_pkg.sv
package tx_phy_seq_pkg;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_WR_ERR   = 2'd1,
        RES_LOCK_TMO = 2'd2,
        RES_UNSUP    = 2'd3
    } seq_res_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_PREP, S_QUIET, S_RST_REL, S_RST_SET,
        S_WR_GO, S_WR_WAIT, S_PWR_ON, S_TMDS_LO, S_TMDS_HI,
        S_TX_ON, S_QUIET_OFF, S_LOCK_GO, S_LOCK_WAIT, S_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] data;
    } phy_wr_t;

    localparam int unsigned N_WRITES = 9;
    localparam int unsigned N_PASSES = 2;

    // pixel clock band limits in kHz
    localparam int unsigned BAND0_MAX_KHZ = 45250;
    localparam int unsigned BAND1_MAX_KHZ = 92500;
    localparam int unsigned BAND2_MAX_KHZ = 185000;
    localparam int unsigned CUR_A_MAX_KHZ = 58400;
    localparam int unsigned CUR_B_MAX_KHZ = 74250;
    localparam int unsigned CUR_C_MAX_KHZ = 118800;
    localparam int unsigned MAX_KHZ       = 216000;
    localparam int unsigned HIRATE_KHZ    = 148500;

    // PHY register addresses
    localparam logic [7:0] A_CPUMP  = 8'h06;
    localparam logic [7:0] A_GAIN   = 8'h15;
    localparam logic [7:0] A_CURR   = 8'h10;
    localparam logic [7:0] A_PLLBY  = 8'h13;
    localparam logic [7:0] A_MSM    = 8'h17;
    localparam logic [7:0] A_TERM   = 8'h19;
    localparam logic [7:0] A_CKCAL  = 8'h05;
    localparam logic [7:0] A_SYMCTL = 8'h09;
    localparam logic [7:0] A_LEVEL  = 8'h0E;

    localparam logic [15:0] CURR_LO   = 16'h091C;
    localparam logic [15:0] CURR_HI   = 16'h06DC;
    localparam logic [15:0] SYM_HIGH  = 16'h800D;
    localparam logic [15:0] SYM_LOW   = 16'h8009;
    localparam logic [4:0]  LVL_HIGH  = 5'd9;
    localparam logic [4:0]  LVL_LOW   = 5'd13;

    function automatic logic [15:0] cpump_val(input logic [1:0] band);
        unique case (band)
            2'd0: cpump_val = 16'h0051;
            2'd1: cpump_val = 16'h00A1;
            2'd2: cpump_val = 16'h0029;
            default: cpump_val = 16'h0040;
        endcase
    endfunction

    function automatic logic [15:0] gain_val(input logic [1:0] band);
        gain_val = {14'd0, ~band};
    endfunction

endpackage

// File: rtl/tx_phy_cfg_rom.sv
module tx_phy_cfg_rom
    import tx_phy_seq_pkg::*;
#(
    parameter int unsigned PCLK_W = 18,
    localparam int unsigned IDX_W = $clog2(N_WRITES)
) (
    input  logic [PCLK_W-1:0] khz_i,
    input  logic [IDX_W-1:0]  idx_i,
    output phy_wr_t           wr_o,
    output logic              unsup_o
);

    int unsigned khz;
    logic [1:0]  band;
    logic [15:0] curr;
    logic        hirate;
    logic [4:0]  lvl;

    always_comb begin
        khz = 32'(khz_i);
        if (khz <= BAND0_MAX_KHZ)      band = 2'd0;
        else if (khz <= BAND1_MAX_KHZ) band = 2'd1;
        else if (khz <= BAND2_MAX_KHZ) band = 2'd2;
        else                           band = 2'd3;

        if (khz <= CUR_A_MAX_KHZ)      curr = CURR_LO;
        else if (khz <= CUR_B_MAX_KHZ) curr = CURR_HI;
        else if (khz <= CUR_C_MAX_KHZ) curr = CURR_LO;
        else                           curr = CURR_HI;

        hirate  = (khz > HIRATE_KHZ);
        lvl     = hirate ? LVL_HIGH : LVL_LOW;
        unsup_o = (khz > MAX_KHZ);

        unique case (32'(idx_i))
            0: wr_o = '{addr: A_CPUMP,  data: cpump_val(band)};
            1: wr_o = '{addr: A_GAIN,   data: gain_val(band)};
            2: wr_o = '{addr: A_CURR,   data: curr};
            3: wr_o = '{addr: A_PLLBY,  data: 16'h0000};
            4: wr_o = '{addr: A_MSM,    data: 16'h0008};
            5: wr_o = '{addr: A_TERM,   data: 16'h0004};
            6: wr_o = '{addr: A_CKCAL,  data: 16'h8000};
            7: wr_o = '{addr: A_SYMCTL, data: hirate ? SYM_HIGH : SYM_LOW};
            default: wr_o = '{addr: A_LEVEL, data: {6'd0, lvl, lvl}};
        endcase
    end

endmodule

// File: rtl/tx_phy_wr_port.sv
module tx_phy_wr_port
    import tx_phy_seq_pkg::*;
#(
    parameter int unsigned TMO_CYC = 1000,
    localparam int unsigned CW = $clog2(TMO_CYC + 1)
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        go_i,
    input  phy_wr_t     wr_i,
    input  logic        done_i,
    input  logic        err_i,
    output logic        clr_o,
    output logic        req_o,
    output logic [7:0]  addr_o,
    output logic [15:0] data_o,
    output logic        fin_o,
    output logic        fail_o
);

    typedef enum logic [1:0] {W_IDLE, W_CLR, W_REQ, W_WAIT} wr_state_e;

    wr_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q;
    phy_wr_t     hold_q;

    always_comb begin
        fin_o  = 1'b0;
        fail_o = 1'b0;
        st_d   = st_q;
        unique case (st_q)
            W_IDLE: if (go_i) st_d = W_CLR;
            W_CLR:  st_d = W_REQ;
            W_REQ:  st_d = W_WAIT;
            W_WAIT: begin
                if (err_i) begin
                    fin_o  = 1'b1;
                    fail_o = 1'b1;
                end else if (done_i) begin
                    fin_o  = 1'b1;
                end else if (cnt_q == CW'(TMO_CYC - 1)) begin
                    fin_o  = 1'b1;
                    fail_o = 1'b1;
                end
                if (fin_o) st_d = W_IDLE;
            end
            default: st_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q   <= W_IDLE;
            cnt_q  <= '0;
            hold_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == W_IDLE && go_i) hold_q <= wr_i;
            if (st_q == W_WAIT) cnt_q <= cnt_q + 1'b1;
            else                cnt_q <= '0;
        end
    end

    assign clr_o  = (st_q == W_CLR);
    assign req_o  = (st_q == W_REQ);
    assign addr_o = hold_q.addr;
    assign data_o = hold_q.data;

endmodule

// File: rtl/tx_phy_lock_poll.sv
module tx_phy_lock_poll #(
    parameter int unsigned POLL_CYC = 1000,
    parameter int unsigned POLLS    = 4,
    localparam int unsigned CW = $clog2(POLL_CYC + 1),
    localparam int unsigned PW = $clog2(POLLS + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    input  logic lock_i,
    output logic ok_o,
    output logic fail_o
);

    logic          act_q;
    logic [CW-1:0] cyc_q;
    logic [PW-1:0] polls_q;
    logic          at_poll;

    assign at_poll = act_q && (cyc_q == '0);
    assign ok_o    = at_poll && lock_i;
    assign fail_o  = at_poll && !lock_i && (polls_q == PW'(POLLS));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_q   <= 1'b0;
            cyc_q   <= '0;
            polls_q <= '0;
        end else if (go_i) begin
            act_q   <= 1'b1;
            cyc_q   <= '0;
            polls_q <= '0;
        end else if (ok_o || fail_o) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            if (cyc_q == CW'(POLL_CYC - 1)) begin
                cyc_q   <= '0;
                polls_q <= polls_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tx_phy_seq.sv
module tx_phy_seq
    import tx_phy_seq_pkg::*;
#(
    parameter int unsigned PCLK_W     = 18,
    parameter int unsigned CLK_HZ     = 200_000_000,
    parameter int unsigned WR_TMO_US  = 1000,
    parameter int unsigned POLL_US    = 1000,
    parameter int unsigned LOCK_POLLS = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [PCLK_W-1:0] pclk_khz_i,
    input  logic              lock_i,
    input  logic              wr_done_i,
    input  logic              wr_err_i,
    output logic              wr_clr_o,
    output logic              wr_req_o,
    output logic [7:0]        wr_addr_o,
    output logic [15:0]       wr_data_o,
    output logic              den_pol_o,
    output logic              if_sel_o,
    output logic              pwr_en_o,
    output logic              tmds_en_o,
    output logic              txpwron_o,
    output logic              pddq_o,
    output logic              phy_rst_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        status_o
);

    localparam int unsigned CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
    localparam int unsigned WR_TMO_CYC = WR_TMO_US * CYC_PER_US;
    localparam int unsigned POLL_CYC   = POLL_US * CYC_PER_US;
    localparam int unsigned IDX_W      = $clog2(N_WRITES);
    localparam int unsigned PASS_W     = $clog2(N_PASSES);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [PASS_W-1:0] pass_q, pass_d;
    logic [PCLK_W-1:0] pclk_q, pclk_d;
    seq_res_e          res_q, res_d;

    phy_wr_t cur_wr;
    logic    unsup;
    logic    wr_fin, wr_fail;
    logic    lk_ok, lk_fail;

    tx_phy_cfg_rom #(.PCLK_W(PCLK_W)) u_rom (
        .khz_i   (pclk_q),
        .idx_i   (idx_q),
        .wr_o    (cur_wr),
        .unsup_o (unsup)
    );

    tx_phy_wr_port #(.TMO_CYC(WR_TMO_CYC)) u_wr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (state_q == S_WR_GO),
        .wr_i   (cur_wr),
        .done_i (wr_done_i),
        .err_i  (wr_err_i),
        .clr_o  (wr_clr_o),
        .req_o  (wr_req_o),
        .addr_o (wr_addr_o),
        .data_o (wr_data_o),
        .fin_o  (wr_fin),
        .fail_o (wr_fail)
    );

    tx_phy_lock_poll #(.POLL_CYC(POLL_CYC), .POLLS(LOCK_POLLS)) u_lock (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (state_q == S_LOCK_GO),
        .lock_i (lock_i),
        .ok_o   (lk_ok),
        .fail_o (lk_fail)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        pass_d  = pass_q;
        pclk_d  = pclk_q;
        res_d   = res_q;
        unique case (state_q)
            S_IDLE: if (start_i) begin
                pclk_d  = pclk_khz_i;
                state_d = S_CHECK;
            end
            S_CHECK: if (unsup) begin
                res_d   = RES_UNSUP;
                state_d = S_FINISH;
            end else begin
                res_d   = RES_OK;
                pass_d  = '0;
                state_d = S_PREP;
            end
            S_PREP:    state_d = S_QUIET;
            S_QUIET:   state_d = S_RST_REL;
            S_RST_REL: state_d = S_RST_SET;
            S_RST_SET: begin
                idx_d   = '0;
                state_d = S_WR_GO;
            end
            S_WR_GO:   state_d = S_WR_WAIT;
            S_WR_WAIT: if (wr_fin) begin
                if (wr_fail) begin
                    res_d   = RES_WR_ERR;
                    state_d = S_FINISH;
                end else if (idx_q == IDX_W'(N_WRITES - 1)) begin
                    state_d = S_PWR_ON;
                end else begin
                    idx_d   = idx_q + 1'b1;
                    state_d = S_WR_GO;
                end
            end
            S_PWR_ON:    state_d = S_TMDS_LO;
            S_TMDS_LO:   state_d = S_TMDS_HI;
            S_TMDS_HI:   state_d = S_TX_ON;
            S_TX_ON:     state_d = S_QUIET_OFF;
            S_QUIET_OFF: state_d = S_LOCK_GO;
            S_LOCK_GO:   state_d = S_LOCK_WAIT;
            S_LOCK_WAIT: if (lk_ok) begin
                if (pass_q == PASS_W'(N_PASSES - 1)) begin
                    res_d   = RES_OK;
                    state_d = S_FINISH;
                end else begin
                    pass_d  = pass_q + 1'b1;
                    state_d = S_PREP;
                end
            end else if (lk_fail) begin
                res_d   = RES_LOCK_TMO;
                state_d = S_FINISH;
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            pass_q  <= '0;
            pclk_q  <= '0;
            res_q   <= RES_OK;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pass_q  <= pass_d;
            pclk_q  <= pclk_d;
            res_q   <= res_d;
        end
    end

    // control outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            den_pol_o <= 1'b0;
            if_sel_o  <= 1'b0;
            pwr_en_o  <= 1'b0;
            tmds_en_o <= 1'b0;
            txpwron_o <= 1'b0;
            pddq_o    <= 1'b1;
            phy_rst_o <= 1'b0;
            done_o    <= 1'b0;
            status_o  <= RES_OK;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                S_PREP: begin
                    den_pol_o <= 1'b1;
                    if_sel_o  <= 1'b0;
                    tmds_en_o <= 1'b0;
                    pwr_en_o  <= 1'b0;
                end
                S_QUIET: begin
                    txpwron_o <= 1'b0;
                    pddq_o    <= 1'b1;
                end
                S_RST_REL:   phy_rst_o <= 1'b0;
                S_RST_SET:   phy_rst_o <= 1'b1;
                S_PWR_ON:    pwr_en_o  <= 1'b1;
                S_TMDS_LO:   tmds_en_o <= 1'b0;
                S_TMDS_HI:   tmds_en_o <= 1'b1;
                S_TX_ON:     txpwron_o <= 1'b1;
                S_QUIET_OFF: pddq_o    <= 1'b0;
                S_FINISH: begin
                    done_o   <= 1'b1;
                    status_o <= res_q;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != S_IDLE);

endmodule

// File: rtl/tx_phy_seq_chk.sv
module tx_phy_seq_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        wr_clr_o,
    input logic        wr_req_o,
    input logic [7:0]  wr_addr_o,
    input logic [15:0] wr_data_o,
    input logic        den_pol_o,
    input logic        if_sel_o,
    input logic        pwr_en_o,
    input logic        tmds_en_o,
    input logic        txpwron_o,
    input logic        pddq_o,
    input logic        phy_rst_o,
    input logic        busy_o,
    input logic        done_o
);

    p_quiet_at_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_o |-> (pddq_o && !txpwron_o && !pwr_en_o && !tmds_en_o && den_pol_o && !if_sel_o));

    p_reset_set_at_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_o |-> phy_rst_o);

    p_clear_before_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_o |-> $past(wr_clr_o));

    p_req_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_o |=> !wr_req_o);

    p_word_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_o |=> ($stable(wr_addr_o) && $stable(wr_data_o)));

    p_tx_on_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(txpwron_o) |-> (pwr_en_o && tmds_en_o && pddq_o));

    p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_when_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    p_no_write_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!wr_req_o && !wr_clr_o));

endmodule

bind tx_phy_seq tx_phy_seq_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_clr_o  (wr_clr_o),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .den_pol_o (den_pol_o),
    .if_sel_o  (if_sel_o),
    .pwr_en_o  (pwr_en_o),
    .tmds_en_o (tmds_en_o),
    .txpwron_o (txpwron_o),
    .pddq_o    (pddq_o),
    .phy_rst_o (phy_rst_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/tb_tx_phy_seq.sv
module tb_tx_phy_seq;

    localparam int POLL_CYC   = 8;
    localparam int LOCK_POLLS = 4;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [17:0] pclk = '0;
    logic        lock_lvl = 1'b0;
    logic        wr_done = 1'b0;
    logic        wr_err = 1'b0;
    logic        wr_clr, wr_req, den_pol, if_sel, pwr_en, tmds_en, txpwron, pddq, phy_rst, busy, done;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic [1:0]  status;

    always #2.5 clk = ~clk;

    tx_phy_seq #(
        .PCLK_W(18), .CLK_HZ(1_000_000), .WR_TMO_US(20),
        .POLL_US(POLL_CYC), .LOCK_POLLS(LOCK_POLLS)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pclk_khz_i(pclk),
        .lock_i(lock_lvl), .wr_done_i(wr_done), .wr_err_i(wr_err),
        .wr_clr_o(wr_clr), .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .den_pol_o(den_pol), .if_sel_o(if_sel), .pwr_en_o(pwr_en), .tmds_en_o(tmds_en),
        .txpwron_o(txpwron), .pddq_o(pddq), .phy_rst_o(phy_rst),
        .busy_o(busy), .done_o(done), .status_o(status)
    );

    typedef struct packed {
        logic [31:0] khz;
        logic [15:0] cpump, gain, curr, sym, lvl;
        logic [1:0]  st;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'd25175,  16'h0051, 16'h0003, 16'h091C, 16'h8009, 16'h01AD, 2'd0},
        '{32'd45250,  16'h0051, 16'h0003, 16'h091C, 16'h8009, 16'h01AD, 2'd0},
        '{32'd45251,  16'h00A1, 16'h0002, 16'h091C, 16'h8009, 16'h01AD, 2'd0},
        '{32'd65000,  16'h00A1, 16'h0002, 16'h06DC, 16'h8009, 16'h01AD, 2'd0},
        '{32'd74251,  16'h00A1, 16'h0002, 16'h091C, 16'h8009, 16'h01AD, 2'd0},
        '{32'd118800, 16'h0029, 16'h0001, 16'h091C, 16'h8009, 16'h01AD, 2'd0},
        '{32'd148500, 16'h0029, 16'h0001, 16'h06DC, 16'h8009, 16'h01AD, 2'd0},
        '{32'd148501, 16'h0029, 16'h0001, 16'h06DC, 16'h800D, 16'h0129, 2'd0},
        '{32'd185001, 16'h0040, 16'h0000, 16'h06DC, 16'h800D, 16'h0129, 2'd0},
        '{32'd216000, 16'h0040, 16'h0000, 16'h06DC, 16'h800D, 16'h0129, 2'd0},
        '{32'd216001, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 2'd3}
    };

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // observation state, owned by the monitor below
    bit          clr_req = 0;
    int          resp_mode = 0;
    logic [7:0]  log_a [32];
    logic [15:0] log_d [32];
    int n_wr, bad_ctl, bad_hs, rst_rises, pddq_falls, dones, done_hi, cyc, t_fall, t_done, resp_cnt;
    logic [1:0] last_st;
    logic prev_rst, prev_pddq, prev_done, prev_clr;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (clr_req) begin
            n_wr = 0; bad_ctl = 0; bad_hs = 0; rst_rises = 0; pddq_falls = 0;
            dones = 0; done_hi = 0; resp_cnt = 0; t_fall = 0; t_done = 0;
        end else begin
            if (wr_req) begin
                if (n_wr < 32) begin
                    log_a[n_wr] = wr_addr;
                    log_d[n_wr] = wr_data;
                end
                n_wr = n_wr + 1;
                if (!(pddq && !txpwron && !pwr_en && !tmds_en && den_pol && !if_sel && phy_rst))
                    bad_ctl = bad_ctl + 1;
                if (!prev_clr) bad_hs = bad_hs + 1;
                resp_cnt = LAT;
            end else if (resp_cnt > 0) begin
                resp_cnt = resp_cnt - 1;
            end
            if (phy_rst && !prev_rst) rst_rises = rst_rises + 1;
            if (!pddq && prev_pddq) begin
                pddq_falls = pddq_falls + 1;
                t_fall = cyc;
            end
            if (done) begin
                done_hi = done_hi + 1;
                last_st = status;
                if (!prev_done) begin
                    dones = dones + 1;
                    t_done = cyc;
                end
            end
        end
        wr_done = (resp_cnt == 1) && (resp_mode == 0);
        wr_err  = (resp_cnt == 1) && (resp_mode == 1);
        prev_rst = phy_rst; prev_pddq = pddq; prev_done = done; prev_clr = wr_clr;
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        clr_req = 1;
        @(negedge clk);
        #1 clr_req = 0;
    endtask

    task automatic pulse_start(input int khz);
        @(negedge clk);
        #1;
        pclk  = 18'(khz);
        start = 1'b1;
        @(negedge clk);
        #1 start = 1'b0;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 3000 && dones == 0; g++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_addr(input int i);
        case (i)
            0: return 8'h06; 1: return 8'h15; 2: return 8'h10;
            3: return 8'h13; 4: return 8'h17; 5: return 8'h19;
            6: return 8'h05; 7: return 8'h09; default: return 8'h0E;
        endcase
    endfunction

    function automatic logic [15:0] exp_data(input vec_t v, input int i);
        case (i)
            0: return v.cpump; 1: return v.gain; 2: return v.curr;
            3: return 16'h0000; 4: return 16'h0008; 5: return 16'h0004;
            6: return 16'h8000; 7: return v.sym; default: return v.lvl;
        endcase
    endfunction

    function automatic string data_tag(input int i);
        case (i)
            0, 1: return "R5";
            2: return "R6";
            7, 8: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R13 watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        cyc = 0; n_wr = 0; bad_ctl = 0; bad_hs = 0; rst_rises = 0; pddq_falls = 0;
        dones = 0; done_hi = 0; resp_cnt = 0; t_fall = 0; t_done = 0; last_st = 2'd0;
        prev_rst = 0; prev_pddq = 1; prev_done = 0; prev_clr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state
        chk(!busy && !done && status == 2'd0, "R13", "idle after reset", {busy, done, status}, 0);
        chk(!wr_req && !wr_clr, "R13", "no write after reset", {wr_req, wr_clr}, 0);
        chk({pddq, txpwron, pwr_en, tmds_en, phy_rst} == 5'b10000, "R13", "control levels after reset",
            {pddq, txpwron, pwr_en, tmds_en, phy_rst}, 5'b10000);

        // vector table
        for (int v = 0; v < NV; v++) begin
            resp_mode = 0;
            lock_lvl  = 1'b1;
            clear_log();
            pulse_start(int'(VECS[v].khz));
            wait_done();
            chk(dones == 1 && done_hi == 1, "R13", "single done pulse", done_hi, 1);
            if (VECS[v].st == 2'd3) begin
                chk(last_st == 2'd3, "R1", "unsupported status", last_st, 3);
                chk(n_wr == 0, "R1", "no writes when unsupported", n_wr, 0);
            end else begin
                chk(last_st == 2'd0, "R9", "ok status", last_st, 0);
                chk(n_wr == 18, "R12", "write count", n_wr, 18);
                for (int w = 0; w < 18 && w < n_wr; w++) begin
                    chk(log_a[w] == exp_addr(w % 9), "R8", "write address", log_a[w], exp_addr(w % 9));
                    chk(log_d[w] == exp_data(VECS[v], w % 9), data_tag(w % 9), "write data",
                        log_d[w], exp_data(VECS[v], w % 9));
                end
                chk(pddq_falls == 2, "R12", "quiet releases", pddq_falls, 2);
                chk(rst_rises == 2, "R3", "reset rises", rst_rises, 2);
                chk(bad_ctl == 0, "R2", "control levels at writes", bad_ctl, 0);
                chk(bad_hs == 0, "R4", "clear before request", bad_hs, 0);
                chk({pwr_en, tmds_en, txpwron, pddq} == 4'b1110, "R9", "final power levels",
                    {pwr_en, tmds_en, txpwron, pddq}, 4'b1110);
            end
        end

        // R10: lock never seen
        lock_lvl = 1'b0;
        clear_log();
        pulse_start(74250);
        wait_done();
        chk(last_st == 2'd2, "R10", "lock timeout status", last_st, 2);
        chk(n_wr == 9, "R10", "only first pass writes", n_wr, 9);
        chk(t_done - t_fall >= LOCK_POLLS * POLL_CYC && t_done - t_fall <= LOCK_POLLS * POLL_CYC + 6,
            "R10", "lock timeout delay", t_done - t_fall, LOCK_POLLS * POLL_CYC);

        // R10: lock arrives between samples
        lock_lvl = 1'b0;
        clear_log();
        pulse_start(100000);
        for (int g = 0; g < 2000 && pddq_falls == 0; g++) @(negedge clk);
        repeat (20) @(negedge clk);
        lock_lvl = 1'b1;
        wait_done();
        chk(last_st == 2'd0, "R10", "late lock accepted", last_st, 0);
        chk(n_wr == 18, "R10", "late lock writes", n_wr, 18);

        // R11: error response
        lock_lvl  = 1'b1;
        resp_mode = 1;
        clear_log();
        pulse_start(65000);
        wait_done();
        chk(last_st == 2'd1, "R11", "error response status", last_st, 1);
        chk(n_wr == 1, "R11", "abort after error", n_wr, 1);

        // R11: no response
        resp_mode = 2;
        clear_log();
        pulse_start(65000);
        wait_done();
        chk(last_st == 2'd1, "R11", "write timeout status", last_st, 1);
        chk(n_wr == 1, "R11", "abort after timeout", n_wr, 1);

        // R13: start while busy ignored
        resp_mode = 0;
        clear_log();
        pulse_start(65000);
        repeat (10) @(negedge clk);
        pulse_start(216001);
        wait_done();
        repeat (10) @(negedge clk);
        chk(dones == 1, "R13", "one run only", dones, 1);
        chk(last_st == 2'd0, "R13", "busy start ignored status", last_st, 0);
        chk(n_wr == 18 && log_d[2] == 16'h06DC, "R13", "first clock kept", log_d[2], 16'h06DC);
        chk(!busy, "R13", "idle after run", busy, 0);

        summary();
    end

endmodule